// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable AND-OR logic array. A set of product terms, each able to take any array signal in its true form, its inverted form, or not at all, feeds a bank of output OR gates. Each OR gate collects a fixed, hard-wired group of neighbouring product terms, and the group size grows with the output index. Only the connections inside the AND plane and a two-bit mode for each output are configurable.

Each output passes through a cell that either drives the OR result straight out or drives a flip-flop copy of it. Either form can be inverted. Every cell's flip-flop is routed back into the AND plane as an extra array signal, so state machines and counters can be built inside the array.

The configuration word is shifted in one bit per clock through a serial port before use. The array signals are the dedicated data inputs followed by one feedback line per output.

Top module: `sop_logic_array`

## Requirements
- R1: A synchronous reset clears every configuration bit and every cell flip-flop. With a cleared configuration, every output reads 0.
- R2: While `cfg_load` is high, one configuration bit is taken from `cfg_bit` on each clock. After a full load of 5300 bits, the first bit sent sits at index 0. The AND-plane bit for product term t, array signal s and polarity p (0 = true, 1 = inverted) is at index t*44 + 2*s + p.
- R3: A product term is the AND of its enabled literals. A term with no literal enabled is 0. A term that enables both polarities of the same signal is 0.
- R4: The OR gate of output o sums 8 + 2*(o/2) consecutive product terms, using integer division. The groups follow one another from term 0 upward, so the ten groups hold 8, 8, 10, 10, 12, 12, 14, 14, 16 and 16 terms, 120 terms in all.
- R5: The mode of output o sits at configuration index 5280 + 2*o (low bit) and 5280 + 2*o + 1 (high bit). The modes are: 00 combinational, true polarity; 01 combinational, inverted; 10 registered, true polarity; 11 registered, inverted.
- R6: On every clock where neither reset nor load is active, each cell flip-flop captures its OR sum. In the registered modes the output shows that flip-flop, inverted in mode 11.
- R7: Array signal 12 + o is the flip-flop of output o in every mode. Array signals 0 to 11 are the data inputs.
- R8: While `cfg_load` is high, all cell flip-flops hold their values.
- R9: While `cfg_load` is low, the configuration is unchanged whatever `cfg_bit` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain and the cell flip-flops |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | High to shift one configuration bit per clock |
| cfg_bit | input | 1 | Serial configuration data |
| data_in | input | 12 | Dedicated array inputs, array signals 0 to 11 |
| pin_out | output | 10 | Output cell results |

## Verification
On every cycle, the assertions check the following: the chain shifts during a load and holds at all other times, each flip-flop captures its OR sum or holds during a load, both reset and load clear or freeze the state as required, and a term with a clashing literal pair stays low. The bench scenarios are the only way to show the parts that depend on the whole configuration. These are the bit placement of a full load, the boundaries between the term groups, the four output modes, and feedback paths that form a toggling flip-flop and chains between cells. The bench also shows that a reload keeps the flip-flop contents.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    CELL_COMB_HI = 2'b00,
    CELL_COMB_LO = 2'b01,
    CELL_REG_HI  = 2'b10,
    CELL_REG_LO  = 2'b11
  } cell_mode_e;

  // product terms owned by output o
  function automatic int terms_of(int o, int min_terms, int step);
    return min_terms + step * (o / 2);
  endfunction

  // first product term owned by output o
  function automatic int base_of(int o, int min_terms, int step);
    int acc;
    acc = 0;
    for (int k = 0; k < o; k++) acc += terms_of(k, min_terms, step);
    return acc;
  endfunction

  // position of one AND-plane connection in the configuration word
  function automatic int fuse_idx(int t, int s, int pol, int n_sig);
    return t * 2 * n_sig + 2 * s + pol;
  endfunction

endpackage

// File: rtl/sop_fuse_chain.sv
module sop_fuse_chain #(
  parameter int LEN = 5300
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           shift_bit,
  output logic [LEN-1:0] fuses
);

  // new bits enter at the top so the first bit lands at index 0
  always_ff @(posedge clk) begin
    if (rst)           fuses <= '0;
    else if (shift_en) fuses <= {shift_bit, fuses[LEN-1:1]};
  end

  assert_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fuses == '0)
    else $error("fuse chain not cleared after reset");

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> fuses[LEN-1] == $past(shift_bit))
    else $error("serial bit not captured");

  assert_shift_move_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> fuses[LEN-2:0] == $past(fuses[LEN-1:1]))
    else $error("chain did not advance by one");

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(fuses))
    else $error("configuration changed while not loading");

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_SIG   = 22,
  parameter int N_TERMS = 120,
  localparam int W      = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]     sig,
  input  logic [N_TERMS*W-1:0] fuses,
  output logic [N_TERMS-1:0]   terms
);

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [W-1:0]     f;
    logic [N_SIG-1:0] lit_ok;
    logic [N_SIG-1:0] clash;

    assign f = fuses[t*W +: W];

    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
      assign lit_ok[s] = (!f[2*s] | sig[s]) & (!f[2*s+1] | !sig[s]);
      assign clash[s]  = f[2*s] & f[2*s+1];
    end

    // an empty term is forced low rather than left as a constant one
    assign terms[t] = (|f) & (&lit_ok);

    always_comb begin
      if (|clash) begin
        assert_clash_zero_R3: assert (terms[t] == 1'b0)
          else $error("term with contradictory literals is high");
      end
    end
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_pkg::*;
#(
  parameter int N_TERMS_G = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic [N_TERMS_G-1:0] terms_g,
  input  cell_mode_e           mode,
  output logic                 pin,
  output logic                 fb
);

  logic or_sum;
  logic q;

  assign or_sum = |terms_g;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (!hold) q <= or_sum;
  end

  always_comb begin
    case (mode)
      CELL_COMB_HI: pin = or_sum;
      CELL_COMB_LO: pin = !or_sum;
      CELL_REG_HI:  pin = q;
      default:      pin = !q;
    endcase
  end

  assign fb = q;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == 1'b0)
    else $error("cell flip-flop not cleared by reset");

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    !hold |=> q == $past(or_sum))
    else $error("cell flip-flop missed its OR sum");

  assert_hold_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q))
    else $error("cell flip-flop moved during load");

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int N_IN      = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] pin_out
);

  localparam int N_SIG     = N_IN + N_OUT;
  localparam int N_TERMS   = base_of(N_OUT, MIN_TERMS, TERM_STEP);
  localparam int AND_BITS  = N_TERMS * 2 * N_SIG;
  localparam int MODE_BASE = AND_BITS;
  localparam int CFG_LEN   = AND_BITS + 2 * N_OUT;

  logic [CFG_LEN-1:0] fuses;
  logic [N_TERMS-1:0] terms;
  logic [N_OUT-1:0]   fb;
  logic [N_SIG-1:0]   sig;

  assign sig = {fb, data_in};

  sop_fuse_chain #(.LEN(CFG_LEN)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (cfg_load),
    .shift_bit (cfg_bit),
    .fuses     (fuses)
  );

  sop_and_plane #(.N_SIG(N_SIG), .N_TERMS(N_TERMS)) u_plane (
    .sig   (sig),
    .fuses (fuses[AND_BITS-1:0]),
    .terms (terms)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_cell
    localparam int BASE = base_of(o, MIN_TERMS, TERM_STEP);
    localparam int CNT  = terms_of(o, MIN_TERMS, TERM_STEP);

    sop_out_cell #(.N_TERMS_G(CNT)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .hold    (cfg_load),
      .terms_g (terms[BASE +: CNT]),
      .mode    (cell_mode_e'(fuses[MODE_BASE + 2*o +: 2])),
      .pin     (pin_out[o]),
      .fb      (fb[o])
    );
  end

endmodule

// File: tb/tb_sop_logic_array.sv
`timescale 1ns/1ps
module tb_sop_logic_array;

  localparam int NI = 12;
  localparam int NO = 10;
  localparam int NS = 22;
  localparam int NT = 120;
  localparam int ANDB = NT * 2 * NS;
  localparam int LEN = ANDB + 2 * NO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic cfg_bit = 1'b0;
  logic [NI-1:0] data_in = '0;
  logic [NO-1:0] pin_out;

  int vectors = 0;
  int miscompares = 0;

  bit fmap  [LEN];
  bit stage [LEN];
  bit [NO-1:0] mregs = '0;

  always #10 clk = ~clk;

  sop_logic_array dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .data_in(data_in), .pin_out(pin_out)
  );

  function automatic int grp_base(int o);
    int b = 0;
    for (int k = 0; k < o; k++) b += 8 + 2 * (k / 2);
    return b;
  endfunction

  function automatic bit mterm(int t, bit [NS-1:0] s);
    bit any = 0;
    bit v = 1;
    for (int i = 0; i < NS; i++) begin
      if (fmap[t*2*NS + 2*i])     begin any = 1; v = v & s[i];  end
      if (fmap[t*2*NS + 2*i + 1]) begin any = 1; v = v & !s[i]; end
    end
    return any & v;
  endfunction

  function automatic bit msum(int o, bit [NS-1:0] s);
    bit r = 0;
    for (int t = grp_base(o); t < grp_base(o) + 8 + 2*(o/2); t++) r |= mterm(t, s);
    return r;
  endfunction

  function automatic bit [NO-1:0] mpins(bit [NI-1:0] d);
    bit [NO-1:0] p;
    bit [NS-1:0] s = {mregs, d};
    for (int o = 0; o < NO; o++) begin
      int m = 2 * int'(fmap[ANDB + 2*o + 1]) + int'(fmap[ANDB + 2*o]);
      case (m)
        0: p[o] = msum(o, s);
        1: p[o] = !msum(o, s);
        2: p[o] = mregs[o];
        default: p[o] = !mregs[o];
      endcase
    end
    return p;
  endfunction

  task automatic compare(string tag);
    bit [NO-1:0] exp_p = mpins(data_in);
    vectors++;
    if (pin_out !== exp_p) begin
      miscompares++;
      $display("FAIL %s: pin_out=%b expected=%b", tag, pin_out, exp_p);
    end
  endtask

  task automatic cycle(bit r, bit ld, bit b, bit [NI-1:0] d, bit chk, string tag);
    bit [NO-1:0] nxt;
    @(negedge clk);
    rst = r; cfg_load = ld; cfg_bit = b; data_in = d;
    #2;
    if (chk) compare(tag);
    if (r) begin
      mregs = '0;
      for (int i = 0; i < LEN; i++) fmap[i] = 0;
    end else if (!ld) begin
      for (int o = 0; o < NO; o++) nxt[o] = msum(o, {mregs, d});
      mregs = nxt;
    end
    @(posedge clk);
  endtask

  task automatic clear_stage();
    for (int i = 0; i < LEN; i++) stage[i] = 0;
  endtask

  task automatic lit(int t, int s, int pol);
    stage[t*2*NS + 2*s + pol] = 1;
  endtask

  task automatic set_mode(int o, int m);
    stage[ANDB + 2*o]     = m[0];
    stage[ANDB + 2*o + 1] = m[1];
  endtask

  task automatic load_stage(bit [NI-1:0] d);
    for (int k = 0; k < LEN; k++) cycle(0, 1, stage[k], d, 0, "R2");
    for (int i = 0; i < LEN; i++) fmap[i] = stage[i];
  endtask

  task automatic build_a();
    clear_stage();
    lit(0, 0, 0); lit(0, 1, 1);                 // o0: in0 & ~in1
    lit(7, 2, 0); lit(7, 3, 0); lit(7, 4, 0);   // o0 last term of group
    set_mode(1, 1); lit(8, 2, 0);               // o1: inverted in2
    lit(16, 3, 0); lit(16, 3, 1);               // o2: clashing term (R3)
    lit(25, 4, 0); lit(25, 5, 0);               // o2 last term
    set_mode(4, 2); lit(36, 6, 0); lit(36, 7, 1); lit(37, 6, 1); lit(37, 7, 0);
    set_mode(5, 3); lit(48, 17, 1);             // o5 toggles on own feedback (R7)
    set_mode(6, 2); lit(60, 16, 0);             // o6 follows o4 flip-flop
    set_mode(7, 1); lit(74, 18, 0); lit(74, 8, 0);
    set_mode(8, 3); lit(103, 10, 1);            // o8 last term of group
    lit(119, 11, 0); lit(119, 17, 0);           // o9: very last term
  endtask

  task automatic build_rand();
    clear_stage();
    for (int t = 0; t < NT; t++) begin
      int n = 1 + int'($urandom % 2);
      for (int k = 0; k < n; k++) lit(t, int'($urandom % NS), int'($urandom % 2));
    end
    for (int o = 0; o < NO; o++) set_mode(o, int'($urandom % 4));
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cycle(1, 0, 0, '0, 0, "R1");
    cycle(1, 0, 0, '0, 0, "R1");
    for (int i = 0; i < 4; i++) cycle(0, 0, 1'($urandom), 12'($urandom), 1, "R1");

    build_a();
    load_stage(12'h000);
    for (int i = 0; i < NI; i++) cycle(0, 0, 1'($urandom), 12'(1 << i), 1, "R3/R4/R5");
    for (int i = 0; i < 300; i++)
      cycle(0, 0, 1'($urandom), 12'($urandom), 1, "R3/R4/R5/R6/R7/R9");

    build_rand();
    load_stage(12'($urandom));
    cycle(0, 0, 0, 12'($urandom), 1, "R8");
    for (int i = 0; i < 400; i++)
      cycle(0, 0, 1'($urandom), 12'($urandom), 1, "R2/R5/R6/R7");

    cycle(1, 0, 0, 12'($urandom), 0, "R1");
    for (int i = 0; i < 3; i++) cycle(0, 0, 1'($urandom), 12'($urandom), 1, "R1");

    build_a();
    load_stage(12'h0);
    for (int i = 0; i < 200; i++)
      cycle(0, 0, 1'($urandom), 12'($urandom), 1, "R6/R7/R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule